// File: doc/BRIEF.md
# Augmented Multi-Counter Step Unit

This block keeps a bank of signed two's complement counters and advances them by one command per clock. A command has two parts. The first is a routing selector that gives every counter a source counter, possibly itself and possibly shared with other counters. The second is a per-counter step of -1, 0 or +1. In the cycle a command is accepted, every counter first takes the old value of its source, with all copies taken at the same moment, and then has its own step added. The registered result is then reported as one zero flag per counter.

Before work starts, software-visible state is not involved. A load strobe writes an arbitrary signed starting value into every counter in one cycle. A step that would run past the most positive or most negative value saturates at that limit and sets a sticky overflow flag, which only a load or reset clears. Commands arrive on a valid/ready pair. Ready drops only while a load is being applied.

Top module: `amcu_top`

## Requirements
- R1: The selector holds one source index per destination counter, 0-based, with the index for counter i in `cmd_sel[i*SEL_W +: SEL_W]`. On an accepted command, counter i takes the pre-command value of counter `cmd_sel` entry i. All copies read the old values at once, and repeated sources are allowed.
- R2: A selector entry whose value is NUM_CTR or greater makes that counter keep its own old value.
- R3: The step for counter i is `cmd_delta[2*i +: 2]`. Code 01 means +1, code 11 means -1, and codes 00 and 10 mean no change. The step is added to the value after reassignment.
- R4: `zero_o[i]` is registered. In the cycle after an accepted command, it shows whether counter i's updated value is zero. `flags_valid` is high for exactly the cycle after each accepted command.
- R5: A step that would pass the most positive or the most negative CTR_W-bit value leaves the counter at that limit and sets `ovf_o`. `ovf_o` stays set until a load or a reset.
- R6: While `load_en` is high, `cmd_ready` is low and any command is ignored. The next cycle, every counter i holds `load_vals[i*CTR_W +: CTR_W]`, `zero_o` reflects those values, `ovf_o` is clear and `flags_valid` is low.
- R7: In a cycle with no load and no accepted command, the counters and `zero_o` hold their values and `flags_valid` is low.
- R8: Synchronous reset clears every counter to zero, sets all `zero_o` bits, clears `ovf_o` and `flags_valid`, and leaves `cmd_ready` high.
- R9: An identity selector (entry i equal to i) changes the counters only by their steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load strobe for the starting values |
| load_vals | input | NUM_CTR*CTR_W | Starting values, counter i at slice i |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_sel | input | NUM_CTR*SEL_W | Source index per destination counter |
| cmd_delta | input | 2*NUM_CTR | Step code per counter |
| zero_o | output | NUM_CTR | Registered zero flag per counter |
| flags_valid | output | 1 | Flags come from the command accepted in the previous cycle |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with three counters of four bits each. With this size, two-bit selector fields include the out-of-range code 3. The bench sweeps every selector value (all 64), every combination of the three meaningful step codes and every starting vector drawn from -1, 0 and +1, which covers every zero-crossing pattern. The four-bit width also puts both saturation limits a few steps away. That makes it cheap to check clamping, stickiness and the clearing by load, along with idle cycles, the reserved step code and a load that collides with a command.

// File: rtl/amcu_pkg.sv
package amcu_pkg;

    // Per-counter step code carried in the command
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_INC  = 2'b01,
        STEP_RSV  = 2'b10,
        STEP_DEC  = 2'b11
    } step_code_e;

    // Decoded step for one lane
    typedef struct packed {
        logic up;
        logic down;
    } step_t;

    // Width of one source index field
    function automatic int idx_w(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic step_t decode_step(logic [1:0] code);
        step_t s;
        s.up   = (step_code_e'(code) == STEP_INC);
        s.down = (step_code_e'(code) == STEP_DEC);
        return s;
    endfunction

endpackage

// File: rtl/amcu_xbar.sv
module amcu_xbar #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 16,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_CTR*CTR_W-1:0] cur_vals,
    input  logic [NUM_CTR*SEL_W-1:0] sel,
    output logic [NUM_CTR*CTR_W-1:0] routed
);

    // One multiplexer per destination; an unmatched index keeps the own value
    for (genvar d = 0; d < NUM_CTR; d++) begin : g_dst
        logic [SEL_W-1:0] src_idx;
        logic [CTR_W-1:0] pick;

        assign src_idx = sel[d*SEL_W +: SEL_W];

        always_comb begin
            pick = cur_vals[d*CTR_W +: CTR_W];
            for (int s = 0; s < NUM_CTR; s++) begin
                if (src_idx == SEL_W'(s)) begin
                    pick = cur_vals[s*CTR_W +: CTR_W];
                end
            end
        end

        assign routed[d*CTR_W +: CTR_W] = pick;
    end

endmodule

// File: rtl/amcu_lane.sv
module amcu_lane
    import amcu_pkg::*;
#(
    parameter int CTR_W = 16
) (
    input  logic [CTR_W-1:0] src_val,
    input  step_t            step,
    output logic [CTR_W-1:0] next_val,
    output logic             sat_hit,
    output logic             is_zero
);

    localparam logic [CTR_W-1:0] POS_LIM = {1'b0, {(CTR_W-1){1'b1}}};
    localparam logic [CTR_W-1:0] NEG_LIM = {1'b1, {(CTR_W-1){1'b0}}};
    localparam logic [CTR_W-1:0] ONE     = {{(CTR_W-1){1'b0}}, 1'b1};

    always_comb begin
        next_val = src_val;
        sat_hit  = 1'b0;
        if (step.up) begin
            if (src_val == POS_LIM) begin
                sat_hit = 1'b1;
            end else begin
                next_val = src_val + ONE;
            end
        end else if (step.down) begin
            if (src_val == NEG_LIM) begin
                sat_hit = 1'b1;
            end else begin
                next_val = src_val - ONE;
            end
        end
    end

    assign is_zero = (next_val == '0);

endmodule

// File: rtl/amcu_top.sv
module amcu_top
    import amcu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 16,
    localparam int SEL_W  = idx_w(NUM_CTR),
    localparam int BANK_W = NUM_CTR * CTR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_en,
    input  logic [BANK_W-1:0]        load_vals,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [NUM_CTR*SEL_W-1:0] cmd_sel,
    input  logic [2*NUM_CTR-1:0]     cmd_delta,
    output logic [NUM_CTR-1:0]       zero_o,
    output logic                     flags_valid,
    output logic                     ovf_o
);

    logic [BANK_W-1:0]  bank_q;
    logic [BANK_W-1:0]  routed;
    logic [BANK_W-1:0]  bank_next;
    logic [NUM_CTR-1:0] lane_zero;
    logic [NUM_CTR-1:0] lane_sat;
    logic [NUM_CTR-1:0] load_zero;
    logic               accept;

    assign cmd_ready = !load_en;
    assign accept    = cmd_valid && cmd_ready;

    amcu_xbar #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .SEL_W   (SEL_W)
    ) u_xbar (
        .cur_vals (bank_q),
        .sel      (cmd_sel),
        .routed   (routed)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
        amcu_lane #(
            .CTR_W (CTR_W)
        ) u_lane (
            .src_val  (routed[i*CTR_W +: CTR_W]),
            .step     (decode_step(cmd_delta[2*i +: 2])),
            .next_val (bank_next[i*CTR_W +: CTR_W]),
            .sat_hit  (lane_sat[i]),
            .is_zero  (lane_zero[i])
        );

        assign load_zero[i] = (load_vals[i*CTR_W +: CTR_W] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q      <= '0;
            zero_o      <= '1;
            flags_valid <= 1'b0;
            ovf_o       <= 1'b0;
        end else if (load_en) begin
            bank_q      <= load_vals;
            zero_o      <= load_zero;
            flags_valid <= 1'b0;
            ovf_o       <= 1'b0;
        end else if (accept) begin
            bank_q      <= bank_next;
            zero_o      <= lane_zero;
            flags_valid <= 1'b1;
            ovf_o       <= ovf_o | (|lane_sat);
        end else begin
            flags_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/amcu_chk.sv
module amcu_chk #(
    parameter int K  = 4,
    parameter int SW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            load_en,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [K*SW-1:0] cmd_sel,
    input logic [2*K-1:0]  cmd_delta,
    input logic [K-1:0]    zero_o,
    input logic            flags_valid,
    input logic            ovf_o
);

    logic [K*SW-1:0] ident_sel;

    always_comb begin
        for (int i = 0; i < K; i++) begin
            ident_sel[i*SW +: SW] = SW'(i);
        end
    end

    assert_flags_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> flags_valid);

    assert_flags_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_ready) |=> !flags_valid);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !load_en) |=> ovf_o);

    assert_load_clears_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !ovf_o);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !cmd_valid) |=> $stable(zero_o));

    assert_identity_no_step_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_sel == ident_sel && cmd_delta == '0)
        |=> $stable(zero_o));

endmodule

bind amcu_top amcu_chk #(
    .K  (NUM_CTR),
    .SW (SEL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_sel     (cmd_sel),
    .cmd_delta   (cmd_delta),
    .zero_o      (zero_o),
    .flags_valid (flags_valid),
    .ovf_o       (ovf_o)
);

// File: tb/amcu_top_test.sv
module amcu_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int K    = 3;
    localparam int W    = 4;
    localparam int SW   = 2;
    localparam int MAXV = 7;
    localparam int MINV = -8;
    localparam int WATCHDOG = 190000;

    logic            clk = 1'b0;
    logic            rst;
    logic            load_en;
    logic [K*W-1:0]  load_vals;
    logic            cmd_valid;
    logic            cmd_ready;
    logic [K*SW-1:0] cmd_sel;
    logic [2*K-1:0]  cmd_delta;
    logic [K-1:0]    zero_o;
    logic            flags_valid;
    logic            ovf_o;

    amcu_top #(.NUM_CTR(K), .CTR_W(W)) uut (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_vals   (load_vals),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_sel     (cmd_sel),
        .cmd_delta   (cmd_delta),
        .zero_o      (zero_o),
        .flags_valid (flags_valid),
        .ovf_o       (ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cycles = 0;
    int   mdl [K];
    logic mdl_ovf;

    function automatic logic [K-1:0] exp_zero();
        logic [K-1:0] z;
        for (int i = 0; i < K; i++) z[i] = (mdl[i] == 0);
        return z;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Called at a negedge; drives a load and samples at the next negedge
    task automatic do_load(int v0, int v1, int v2);
        int v [K];
        v[0] = v0; v[1] = v1; v[2] = v2;
        load_en   = 1'b1;
        cmd_valid = 1'b0;
        for (int i = 0; i < K; i++) load_vals[i*W +: W] = W'(v[i]);
        @(negedge clk);
        load_en = 1'b0;
        for (int i = 0; i < K; i++) mdl[i] = v[i];
        mdl_ovf = 1'b0;
        check("R6 load zero flags", 32'(zero_o), 32'(exp_zero()));
        check("R6 load flags_valid", 32'(flags_valid), 32'd0);
        check("R6 load ovf", 32'(ovf_o), 32'd0);
    endtask

    task automatic model_step(logic [K*SW-1:0] sel, logic [2*K-1:0] dl);
        int tmp [K];
        for (int i = 0; i < K; i++) begin
            int src;
            src = int'(sel[i*SW +: SW]);
            tmp[i] = (src < K) ? mdl[src] : mdl[i];
        end
        for (int i = 0; i < K; i++) begin
            int s;
            s = tmp[i];
            if (dl[2*i +: 2] == 2'b01) s = s + 1;
            if (dl[2*i +: 2] == 2'b11) s = s - 1;
            if (s > MAXV) begin s = MAXV; mdl_ovf = 1'b1; end
            if (s < MINV) begin s = MINV; mdl_ovf = 1'b1; end
            mdl[i] = s;
        end
    endtask

    task automatic do_cmd(logic [K*SW-1:0] sel, logic [2*K-1:0] dl, string req);
        cmd_valid = 1'b1;
        cmd_sel   = sel;
        cmd_delta = dl;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_step(sel, dl);
        check(req, 32'(zero_o), 32'(exp_zero()));
        check("R4 flags_valid after accept", 32'(flags_valid), 32'd1);
        check("R5 ovf", 32'(ovf_o), 32'(mdl_ovf));
    endtask

    localparam logic [K*SW-1:0] IDENT = {2'd2, 2'd1, 2'd0};
    localparam logic [1:0] CODES [3] = '{2'b00, 2'b01, 2'b11};

    initial begin
        rst = 1'b1; load_en = 1'b0; load_vals = '0;
        cmd_valid = 1'b0; cmd_sel = '0; cmd_delta = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        check("R8 zero_o after reset", 32'(zero_o), 32'h7);
        check("R8 flags_valid after reset", 32'(flags_valid), 32'd0);
        check("R8 ovf after reset", 32'(ovf_o), 32'd0);
        check("R8 cmd_ready after reset", 32'(cmd_ready), 32'd1);

        // R1 R2 R3 R9 sweep: every selector, every step combo, starts in -1..1
        for (int a = -1; a <= 1; a++)
        for (int b = -1; b <= 1; b++)
        for (int c = -1; c <= 1; c++)
        for (int s = 0; s < 64; s++)
        for (int d = 0; d < 27; d++) begin
            logic [K*SW-1:0] sel;
            logic [2*K-1:0]  dl;
            string req;
            sel = 6'(s);
            dl  = {CODES[(d/9)%3], CODES[(d/3)%3], CODES[d%3]};
            if (sel == IDENT) req = "R9 R3 identity";
            else if (sel[1:0] == 2'd3 || sel[3:2] == 2'd3 || sel[5:4] == 2'd3)
                req = "R2 R3 out-of-range index";
            else req = "R1 R3 reassignment";
            do_load(a, b, c);
            do_cmd(sel, dl, req);
        end

        // R3 reserved code 10 means no change
        do_load(0, 1, -1);
        do_cmd(IDENT, 6'b10_10_10, "R3 reserved step code");

        // R5 saturation at both limits and stickiness
        do_load(7, -8, 0);
        do_cmd(IDENT, 6'b00_11_01, "R5 saturate");
        check("R5 ovf set", 32'(ovf_o), 32'd1);
        for (int n = 0; n < 7; n++) do_cmd(IDENT, 6'b00_00_11, "R5 count down after clamp");
        check("R5 counter0 clamped at 7 reaches zero", 32'(zero_o[0]), 32'd1);
        check("R5 ovf sticky", 32'(ovf_o), 32'd1);
        do_cmd({2'd1, 2'd0, 2'd2}, 6'b00_01_00, "R5 R1 saturated value copied");
        do_load(2, 0, 0);
        check("R6 load clears ovf", 32'(ovf_o), 32'd0);

        // R7 idle cycles hold
        do_load(1, 0, -1);
        repeat (3) begin
            @(negedge clk);
            check("R7 idle flags_valid", 32'(flags_valid), 32'd0);
            check("R7 idle zero_o", 32'(zero_o), 32'(exp_zero()));
        end
        do_cmd(IDENT, 6'b01_00_11, "R7 values held across idle");

        // R6 load collides with a command
        load_en   = 1'b1;
        cmd_valid = 1'b1;
        cmd_sel   = IDENT;
        cmd_delta = 6'b01_01_01;
        load_vals = {4'(0), 4'(0), 4'(5)};
        #1;
        check("R6 cmd_ready low during load", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        load_en = 1'b0;
        cmd_valid = 1'b0;
        mdl[0] = 5; mdl[1] = 0; mdl[2] = 0; mdl_ovf = 1'b0;
        check("R6 command ignored during load", 32'(zero_o), 32'(exp_zero()));
        check("R6 flags_valid low after load", 32'(flags_valid), 32'd0);
        do_cmd(IDENT, 6'b00_00_00, "R6 loaded values intact");

        finish_run();
    end

endmodule